// File: doc/BRIEF.md
# Shader Operand Preparation Unit

This block prepares the three ALU input operands (A, B and C) for one instruction slot of a four-channel FP32 shader datapath. It takes three RGBA source vectors, already read from the register files, together with the 8-bit address field and constant flag of each source. When a source address names an inline constant, the block replaces that source with the constant's value, expanded to FP32 and copied to all four channels. It then forms a fifth candidate, the pre-subtract operand, from the first two decoded sources using one of four arithmetic modes.

For each of the three ALU inputs, a 2-bit select picks one of the four candidates. A per-channel 3-bit swizzle code either routes one of the candidate's channels or forces a constant. A 2-bit input modifier then adjusts the sign. The datapath is combinational. A parameter adds one output register stage, which has a synchronous active-high reset. Register storage, relative addressing and the arithmetic that consumes the prepared operands belong to other blocks.

Top module: `osp_operand_prep`

## Requirements
- R1: With the output stage enabled (the default), each prepared operand appears on `prep_out` one clock edge after its inputs, and a clock edge with `rst` high clears every output bit to zero.
- R2: Operand select code 0 picks decoded source 0, code 1 picks decoded source 1, code 2 picks decoded source 2 and code 3 picks the pre-subtract vector. Vector channel c (0 = R, 1 = G, 2 = B, 3 = A) sits in bits [32c+31:32c].
- R3: A source with constant flag 0 and address bit 7 set is replaced in all four channels by an inline constant. Address bits [6:3] are a 4-bit exponent e with bias 7 and bits [2:0] a mantissa m. For e ≠ 0 the value is (1 + m/8)·2^(e−7), exactly encoded in FP32.
- R4: An inline code with e = 0 is a denormal whose value is m·2^−9, returned as the normalised FP32 value, with code 0 giving +0.0.
- R5: A source whose constant flag is 1, or whose address bit 7 is clear, passes its input vector through unchanged.
- R6: Pre-subtract mode 0 computes 1.0 − 2·s0, mode 1 computes s1 − s0, mode 2 computes s1 + s0 and mode 3 computes 1.0 − s0. The result is formed per channel from the decoded sources, and an exactly zero sum is +0.0.
- R7: Swizzle codes 0, 1, 2 and 3 route channel R, G, B or A of the selected candidate. Output channel c of input i is governed by `in_swz[i]` bits [3c+2:3c].
- R8: Swizzle code 4 yields 0.0, code 5 yields 0.5, code 6 yields 1.0, and the unused code 7 also yields 0.0.
- R9: After the swizzle, modifier 0 passes the value, 1 inverts the sign bit, 2 clears the sign bit and 3 sets it. Exponent and mantissa bits are never changed.
- R10: Each of the three ALU inputs uses only its own select, swizzle and modifier fields. Index 0 is input A, 1 is B and 2 is C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| src_vec | input | 3 x 128 | Source vectors from the register files, channel R in the low word |
| src_addr | input | 3 x 8 | Raw source address fields |
| src_const | input | 3 | Constant flag of each source address |
| presub_op | input | 2 | Pre-subtract mode |
| in_sel | input | 3 x 2 | Operand select for inputs A, B, C |
| in_swz | input | 3 x 12 | Per-channel swizzle codes for inputs A, B, C |
| in_mod | input | 3 x 2 | Input modifier for inputs A, B, C |
| prep_out | output | 3 x 128 | Prepared operand vectors A, B, C |

## Verification
The bound checker examines every cycle for the behaviour that can be seen from the control fields alone. This covers the forced constant values of swizzle codes 4 to 7, the sign produced by the absolute and negative-absolute modifiers, and the outputs holding steady while all inputs hold steady. The numeric results need the bench's directed scenarios, because they depend on the data. These results are the inline-constant expansion across all 128 codes, the four pre-subtract modes, channel routing and negation, the candidate select, and the independence of the three inputs. The bench computes its expected values with real arithmetic.

// File: rtl/osp_pkg.sv
`timescale 1ns/1ps
package osp_pkg;
  localparam int FP_W = 32;
  localparam logic [FP_W-1:0] FP_ZERO = 32'h0000_0000;
  localparam logic [FP_W-1:0] FP_HALF = 32'h3F00_0000;
  localparam logic [FP_W-1:0] FP_ONE  = 32'h3F80_0000;

  typedef enum logic [1:0] {
    PS_ONE_MINUS_2S0 = 2'd0,
    PS_S1_MINUS_S0   = 2'd1,
    PS_S1_PLUS_S0    = 2'd2,
    PS_ONE_MINUS_S0  = 2'd3
  } presub_e;

  typedef enum logic [1:0] {
    MOD_PASS = 2'd0,
    MOD_NEG  = 2'd1,
    MOD_ABS  = 2'd2,
    MOD_NABS = 2'd3
  } mod_e;

  localparam logic [2:0] SWZ_ZERO = 3'd4;
  localparam logic [2:0] SWZ_HALF = 3'd5;
  localparam logic [2:0] SWZ_ONE  = 3'd6;

  function automatic logic [FP_W-1:0] fp_negate(input logic [FP_W-1:0] x);
    return {~x[FP_W-1], x[FP_W-2:0]};
  endfunction
endpackage

// File: rtl/osp_inline_dec.sv
`timescale 1ns/1ps
module osp_inline_dec
  import osp_pkg::*;
(
  input  logic [6:0]      code,
  output logic [FP_W-1:0] value
);
  logic [3:0] ex;
  logic [2:0] mn;

  assign ex = code[6:3];
  assign mn = code[2:0];

  always_comb begin
    value = FP_ZERO;
    if (ex != 4'd0) begin
      value = {1'b0, 8'({4'd0, ex}) + 8'd120, mn, 20'd0};
    end else if (mn[2]) begin
      value = {1'b0, 8'd120, mn[1:0], 21'd0};
    end else if (mn[1]) begin
      value = {1'b0, 8'd119, mn[0], 22'd0};
    end else if (mn[0]) begin
      value = {1'b0, 8'd118, 23'd0};
    end
  end
endmodule

// File: rtl/osp_fadd.sv
`timescale 1ns/1ps
module osp_fadd
  import osp_pkg::*;
(
  input  logic [FP_W-1:0] a,
  input  logic [FP_W-1:0] b,
  output logic [FP_W-1:0] y
);
  localparam int MW = 27;

  logic [FP_W-1:0] lv, sv;
  logic [7:0]      d;
  logic [MW-1:0]   ml, ms, al, mask, n;
  logic [MW:0]     sum;
  logic [4:0]      lz;
  logic            found, st, up;
  logic signed [9:0] ex;
  logic [24:0]     mr;
  logic [22:0]     mant;

  always_comb begin
    y     = FP_ZERO;
    lv    = a;
    sv    = b;
    d     = 8'd0;
    ml    = '0;
    ms    = '0;
    al    = '0;
    mask  = '0;
    n     = '0;
    sum   = '0;
    lz    = 5'd0;
    found = 1'b0;
    st    = 1'b0;
    up    = 1'b0;
    ex    = 10'sd0;
    mr    = '0;
    mant  = '0;
    if (a[30:23] == 8'hFF) begin
      y = a;
    end else if (b[30:23] == 8'hFF) begin
      y = b;
    end else if (a[30:23] == 8'd0 && b[30:23] == 8'd0) begin
      y = FP_ZERO;
    end else if (a[30:23] == 8'd0) begin
      y = b;
    end else if (b[30:23] == 8'd0) begin
      y = a;
    end else begin
      if (a[30:0] < b[30:0]) begin
        lv = b;
        sv = a;
      end
      d    = lv[30:23] - sv[30:23];
      ml   = {1'b1, lv[22:0], 3'b000};
      ms   = {1'b1, sv[22:0], 3'b000};
      mask = (27'd1 << d) - 27'd1;
      if (d >= 8'd27) begin
        al = 27'd1;
      end else begin
        al = ms >> d;
        st = |(ms & mask);
        al[0] = al[0] | st;
      end
      if (lv[31] ^ sv[31]) sum = {1'b0, ml} - {1'b0, al};
      else                 sum = {1'b0, ml} + {1'b0, al};
      ex = signed'({2'b00, lv[30:23]});
      if (sum == '0) begin
        y = FP_ZERO;
      end else begin
        if (sum[MW]) begin
          n  = {sum[MW:2], sum[1] | sum[0]};
          ex = ex + 10'sd1;
        end else begin
          for (int i = MW - 1; i >= 0; i--) begin
            if (!found && sum[i]) begin
              lz    = 5'(MW - 1 - i);
              found = 1'b1;
            end
          end
          n  = sum[MW-1:0] << lz;
          ex = ex - signed'({5'd0, lz});
        end
        up = n[2] & (n[1] | n[0] | n[3]);
        mr = {1'b0, n[26:3]} + {24'd0, up};
        if (mr[24]) begin
          ex   = ex + 10'sd1;
          mant = mr[23:1];
        end else begin
          mant = mr[22:0];
        end
        if (ex <= 10'sd0)        y = {lv[31], 31'd0};
        else if (ex >= 10'sd255) y = {lv[31], 8'hFF, 23'd0};
        else                     y = {lv[31], ex[7:0], mant};
      end
    end
  end
endmodule

// File: rtl/osp_presub.sv
`timescale 1ns/1ps
module osp_presub
  import osp_pkg::*;
#(
  parameter int CH = 4,
  localparam int VW = CH * FP_W
) (
  input  logic [VW-1:0] s0,
  input  logic [VW-1:0] s1,
  input  logic [1:0]    op,
  output logic [VW-1:0] sp
);
  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [FP_W-1:0] x0, x1, dbl, opa, opb, res;

    assign x0 = s0[c*FP_W +: FP_W];
    assign x1 = s1[c*FP_W +: FP_W];

    always_comb begin
      if (x0[30:23] == 8'd0)        dbl = x0;
      else if (x0[30:23] >= 8'd254) dbl = {x0[31], 8'hFF, 23'd0};
      else                          dbl = {x0[31], x0[30:23] + 8'd1, x0[22:0]};
    end

    always_comb begin
      case (presub_e'(op))
        PS_ONE_MINUS_2S0: begin opa = FP_ONE; opb = fp_negate(dbl); end
        PS_S1_MINUS_S0:   begin opa = x1;     opb = fp_negate(x0);  end
        PS_S1_PLUS_S0:    begin opa = x1;     opb = x0;             end
        default:          begin opa = FP_ONE; opb = fp_negate(x0);  end
      endcase
    end

    osp_fadd u_add (.a(opa), .b(opb), .y(res));

    assign sp[c*FP_W +: FP_W] = res;
  end
endmodule

// File: rtl/osp_lane.sv
`timescale 1ns/1ps
module osp_lane
  import osp_pkg::*;
#(
  parameter int CH   = 4,
  parameter int NCAND = 4,
  localparam int VW  = CH * FP_W,
  localparam int SW  = 3 * CH,
  localparam int SELW = $clog2(NCAND)
) (
  input  logic [NCAND-1:0][VW-1:0] cand,
  input  logic [SELW-1:0]          sel,
  input  logic [SW-1:0]            swz,
  input  logic [1:0]               md,
  output logic [VW-1:0]            q
);
  logic [VW-1:0] picked;

  assign picked = cand[sel];

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [2:0]      code;
    logic [FP_W-1:0] base, modded;

    assign code = swz[3*c +: 3];

    always_comb begin
      if (code < 3'd4) begin
        base = picked[32'(code)*FP_W +: FP_W];
      end else begin
        case (code)
          SWZ_HALF: base = FP_HALF;
          SWZ_ONE:  base = FP_ONE;
          default:  base = FP_ZERO;
        endcase
      end
    end

    always_comb begin
      case (mod_e'(md))
        MOD_NEG:  modded = fp_negate(base);
        MOD_ABS:  modded = {1'b0, base[FP_W-2:0]};
        MOD_NABS: modded = {1'b1, base[FP_W-2:0]};
        default:  modded = base;
      endcase
    end

    assign q[c*FP_W +: FP_W] = modded;
  end
endmodule

// File: rtl/osp_operand_prep.sv
`timescale 1ns/1ps
module osp_operand_prep
  import osp_pkg::*;
#(
  parameter int CH      = 4,
  parameter int NSRC    = 3,
  parameter int NIN     = 3,
  parameter int ADDR_W  = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int VW     = CH * FP_W,
  localparam int SW     = 3 * CH
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NSRC-1:0][VW-1:0]    src_vec,
  input  logic [NSRC-1:0][ADDR_W-1:0] src_addr,
  input  logic [NSRC-1:0]            src_const,
  input  logic [1:0]                 presub_op,
  input  logic [NIN-1:0][1:0]        in_sel,
  input  logic [NIN-1:0][SW-1:0]     in_swz,
  input  logic [NIN-1:0][1:0]        in_mod,
  output logic [NIN-1:0][VW-1:0]     prep_out
);
  localparam int NCAND = NSRC + 1;

  logic [NCAND-1:0][VW-1:0] cand;
  logic [NIN-1:0][VW-1:0]   prep_d;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [FP_W-1:0] ival;
    logic            use_inline;

    osp_inline_dec u_dec (.code(src_addr[s][6:0]), .value(ival));

    assign use_inline = !src_const[s] && src_addr[s][ADDR_W-1];
    assign cand[s]    = use_inline ? {CH{ival}} : src_vec[s];
  end

  osp_presub #(.CH(CH)) u_presub (
    .s0 (cand[0]),
    .s1 (cand[1]),
    .op (presub_op),
    .sp (cand[NSRC])
  );

  for (genvar i = 0; i < NIN; i++) begin : g_in
    osp_lane #(.CH(CH), .NCAND(NCAND)) u_lane (
      .cand (cand),
      .sel  (in_sel[i]),
      .swz  (in_swz[i]),
      .md   (in_mod[i]),
      .q    (prep_d[i])
    );
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) prep_out <= '0;
      else     prep_out <= prep_d;
    end
  end else begin : g_comb
    assign prep_out = prep_d;
  end
endmodule

// File: rtl/osp_operand_prep_chk.sv
`timescale 1ns/1ps
module osp_operand_prep_chk
  import osp_pkg::*;
#(
  parameter int CH      = 4,
  parameter int NSRC    = 3,
  parameter int NIN     = 3,
  parameter int ADDR_W  = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int VW     = CH * FP_W,
  localparam int SW     = 3 * CH
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NSRC-1:0][VW-1:0]     src_vec,
  input logic [NSRC-1:0][ADDR_W-1:0] src_addr,
  input logic [NSRC-1:0]             src_const,
  input logic [1:0]                  presub_op,
  input logic [NIN-1:0][1:0]         in_sel,
  input logic [NIN-1:0][SW-1:0]      in_swz,
  input logic [NIN-1:0][1:0]         in_mod,
  input logic [NIN-1:0][VW-1:0]      prep_out
);
  if (OUT_REG) begin : g_chk
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $stable(src_vec) && $stable(src_addr) && $stable(src_const) &&
       $stable(presub_op) && $stable(in_sel) && $stable(in_swz) && $stable(in_mod))
      |=> $stable(prep_out)); // R1

    for (genvar i = 0; i < NIN; i++) begin : g_in
      for (genvar c = 0; c < CH; c++) begin : g_ch
        AST_SWZ_ONE: assert property (@(posedge clk) disable iff (rst)
          ($past(!rst) && $past(in_swz[i][3*c +: 3]) == SWZ_ONE)
          |-> prep_out[i][c*FP_W +: FP_W-1] == FP_ONE[FP_W-2:0]); // R8
        AST_SWZ_HALF: assert property (@(posedge clk) disable iff (rst)
          ($past(!rst) && $past(in_swz[i][3*c +: 3]) == SWZ_HALF)
          |-> prep_out[i][c*FP_W +: FP_W-1] == FP_HALF[FP_W-2:0]); // R8
        AST_SWZ_ZERO: assert property (@(posedge clk) disable iff (rst)
          ($past(!rst) && ($past(in_swz[i][3*c +: 3]) == SWZ_ZERO ||
                           $past(in_swz[i][3*c +: 3]) == 3'd7))
          |-> prep_out[i][c*FP_W +: FP_W-1] == '0); // R8
        AST_MOD_ABS: assert property (@(posedge clk) disable iff (rst)
          ($past(!rst) && $past(in_mod[i]) == MOD_ABS)
          |-> !prep_out[i][c*FP_W + FP_W-1]); // R9
        AST_MOD_NABS: assert property (@(posedge clk) disable iff (rst)
          ($past(!rst) && $past(in_mod[i]) == MOD_NABS)
          |-> prep_out[i][c*FP_W + FP_W-1]); // R9
      end
    end
  end
endmodule

bind osp_operand_prep osp_operand_prep_chk #(
  .CH(CH), .NSRC(NSRC), .NIN(NIN), .ADDR_W(ADDR_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst(rst), .src_vec(src_vec), .src_addr(src_addr),
  .src_const(src_const), .presub_op(presub_op), .in_sel(in_sel),
  .in_swz(in_swz), .in_mod(in_mod), .prep_out(prep_out)
);

// File: tb/osp_operand_prep_bench.sv
`timescale 1ns/1ps
module osp_operand_prep_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0][127:0] src_vec;
  logic [2:0][7:0]   src_addr;
  logic [2:0]        src_const;
  logic [1:0]        presub_op;
  logic [2:0][1:0]   in_sel;
  logic [2:0][11:0]  in_swz;
  logic [2:0][1:0]   in_mod;
  logic [2:0][127:0] prep_out;

  int n_chk  = 0;
  int n_fail = 0;

  localparam logic [11:0] IDENT = {3'd3, 3'd2, 3'd1, 3'd0};

  always #2.5 clk = ~clk;

  osp_operand_prep u_osp_operand_prep (
    .clk(clk), .rst(rst), .src_vec(src_vec), .src_addr(src_addr),
    .src_const(src_const), .presub_op(presub_op), .in_sel(in_sel),
    .in_swz(in_swz), .in_mod(in_mod), .prep_out(prep_out)
  );

  function automatic real f2r(input logic [31:0] x);
    real v;
    if (x[30:23] == 8'd0) return 0.0;
    v = (1.0 + real'(x[22:0]) / 8388608.0) * (2.0 ** (real'(int'(x[30:23]) - 127)));
    return x[31] ? -v : v;
  endfunction

  function automatic logic [31:0] r2f(input real v);
    real a;
    int  e;
    logic s;
    logic [31:0] m;
    if (v == 0.0) return 32'h0;
    s = (v < 0.0);
    a = s ? -v : v;
    e = 127;
    while (a >= 2.0) begin a = a / 2.0; e++; end
    while (a < 1.0)  begin a = a * 2.0; e--; end
    m = 32'($rtoi((a - 1.0) * 8388608.0));
    return {s, 8'(e), m[22:0]};
  endfunction

  function automatic logic [31:0] mini_ref(input int code);
    int e, m;
    e = code / 8;
    m = code % 8;
    if (e == 0) return r2f(real'(m) * (2.0 ** -9.0));
    return r2f((1.0 + real'(m) / 8.0) * (2.0 ** real'(e - 7)));
  endfunction

  function automatic logic [31:0] chan(input logic [127:0] v, input int c);
    return v[32*c +: 32];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    src_vec   = '0;
    src_addr  = '0;
    src_const = '0;
    presub_op = 2'd0;
    in_sel    = '0;
    in_swz    = {3{IDENT}};
    in_mod    = '0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk);
    src_vec = {3{128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF}};
    step();
    for (int i = 0; i < 3; i++)
      for (int c = 0; c < 4; c++)
        chk("R1 reset clears output", chan(prep_out[i], c), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    idle_inputs();
    step();
  endtask

  task automatic t_latency();
    @(negedge clk);
    idle_inputs();
    src_vec[0] = {32'h4080_0000, 32'h4040_0000, 32'h4000_0000, 32'h3F80_0000};
    #1;
    chk("R1 output waits for edge", chan(prep_out[0], 0), 32'h0);
    step();
    chk("R1 output after one edge", chan(prep_out[0], 0), 32'h3F80_0000);
    chk("R1 output after one edge", chan(prep_out[0], 3), 32'h4080_0000);
  endtask

  task automatic t_inline_all();
    for (int k = 0; k < 128; k++) begin
      @(negedge clk);
      idle_inputs();
      src_vec[0]  = {4{32'hDEAD_BEEF}};
      src_addr[0] = {1'b1, 7'(k)};
      step();
      for (int c = 0; c < 4; c++)
        chk((k < 8) ? "R4 inline denormal" : "R3 inline constant",
            chan(prep_out[0], c), mini_ref(k));
    end
  endtask

  task automatic t_passthrough();
    logic [127:0] pat;
    pat = {32'h4110_0000, 32'hC020_0000, 32'h3E80_0000, 32'h4248_0000};
    @(negedge clk);
    idle_inputs();
    src_vec[1] = pat;
    src_addr[1] = 8'h85;
    src_const[1] = 1'b1;
    in_sel[1] = 2'd1;
    step();
    for (int c = 0; c < 4; c++)
      chk("R5 constant flag passes vector", chan(prep_out[1], c), chan(pat, c));
    @(negedge clk);
    src_addr[1] = 8'h05;
    src_const[1] = 1'b0;
    step();
    for (int c = 0; c < 4; c++)
      chk("R5 temporary address passes vector", chan(prep_out[1], c), chan(pat, c));
    @(negedge clk);
    src_addr[1] = 8'h85;
    step();
    chk("R3 inline replaces source", chan(prep_out[1], 2), mini_ref(5));
  endtask

  task automatic t_select();
    @(negedge clk);
    idle_inputs();
    src_vec[0] = {4{32'h3F80_0000}};
    src_vec[1] = {4{32'h4000_0000}};
    src_vec[2] = {4{32'h4040_0000}};
    presub_op  = 2'd2;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      in_sel[2] = 2'(s);
      step();
      chk("R2 operand select", chan(prep_out[2], 1),
          (s == 3) ? r2f(3.0) : r2f(real'(s + 1)));
    end
  endtask

  task automatic t_swizzle_mod();
    logic [127:0] v;
    logic [31:0]  base, expv;
    int code;
    v = {32'hC0A0_0000, 32'h3FC0_0000, 32'hBF00_0000, 32'h4100_0000};
    for (int k = 0; k < 8; k++) begin
      for (int md = 0; md < 4; md++) begin
        @(negedge clk);
        idle_inputs();
        src_vec[1] = v;
        in_sel[2]  = 2'd1;
        for (int c = 0; c < 4; c++) in_swz[2][3*c +: 3] = 3'((k + c) % 8);
        in_mod[2]  = 2'(md);
        step();
        for (int c = 0; c < 4; c++) begin
          code = (k + c) % 8;
          if (code < 4)       base = chan(v, code);
          else if (code == 5) base = 32'h3F00_0000;
          else if (code == 6) base = 32'h3F80_0000;
          else                base = 32'h0;
          case (md)
            1: expv = {~base[31], base[30:0]};
            2: expv = {1'b0, base[30:0]};
            3: expv = {1'b1, base[30:0]};
            default: expv = base;
          endcase
          chk((code < 4) ? "R7 R9 channel route and modifier" : "R8 R9 forced constant and modifier",
              chan(prep_out[2], c), expv);
        end
      end
    end
  endtask

  task automatic t_presub();
    real s0[4] = '{0.75, -1.5, 2.0, 0.125};
    real s1[4] = '{3.0, 0.5, -2.0, 10.0};
    real e;
    for (int op = 0; op < 4; op++) begin
      @(negedge clk);
      idle_inputs();
      for (int c = 0; c < 4; c++) begin
        src_vec[0][32*c +: 32] = r2f(s0[c]);
        src_vec[1][32*c +: 32] = r2f(s1[c]);
      end
      presub_op = 2'(op);
      in_sel[0] = 2'd3;
      step();
      for (int c = 0; c < 4; c++) begin
        case (op)
          0: e = 1.0 - 2.0 * s0[c];
          1: e = s1[c] - s0[c];
          2: e = s1[c] + s0[c];
          default: e = 1.0 - s0[c];
        endcase
        chk("R6 pre-subtract mode", chan(prep_out[0], c), r2f(e));
      end
    end
    @(negedge clk);
    src_addr[0] = 8'hB8;
    presub_op   = 2'd3;
    step();
    chk("R6 pre-subtract on inline one", chan(prep_out[0], 2), 32'h0);
  endtask

  task automatic t_independent();
    @(negedge clk);
    idle_inputs();
    src_vec[0] = {32'h4080_0000, 32'h4040_0000, 32'h4000_0000, 32'h3F80_0000};
    src_vec[2] = {32'hC080_0000, 32'hC040_0000, 32'hC000_0000, 32'hBF80_0000};
    in_sel = {2'd2, 2'd0, 2'd0};
    in_swz = {IDENT, {3'd0, 3'd0, 3'd0, 3'd3}, {3'd6, 3'd6, 3'd6, 3'd1}};
    in_mod = {2'd2, 2'd1, 2'd0};
    step();
    chk("R10 input A own fields", chan(prep_out[0], 0), 32'h4000_0000);
    chk("R10 input A own fields", chan(prep_out[0], 1), 32'h3F80_0000);
    chk("R10 input B own fields", chan(prep_out[1], 0), 32'hC080_0000);
    chk("R10 input B own fields", chan(prep_out[1], 3), 32'hBF80_0000);
    chk("R10 input C own fields", chan(prep_out[2], 1), 32'h4000_0000);
    chk("R10 input C own fields", chan(prep_out[2], 3), 32'h4080_0000);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle_inputs();
    t_reset();
    t_latency();
    t_inline_all();
    t_passthrough();
    t_select();
    t_swizzle_mod();
    t_presub();
    t_independent();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule